// File: doc/BRIEF.md
# Predicated Load-Store Processor Core

A compact multi-cycle processor that runs a program held in a single word-addressed memory. It fetches one 32-bit word per instruction from the address in the program counter. It splits the word into an opcode, a condition mask, a destination register, two source registers and a signed 10-bit offset. It then either carries the instruction out or skips it. Every instruction is guarded. The core ANDs the mask with the live 4-bit condition code, and an instruction whose AND is zero does nothing except advance the program counter.

The register set has sixteen entries. Entry 0 always reads zero and entry 15 is the program counter. There is no branch opcode. The counter is stepped before the result is written back, so any instruction whose destination is entry 15 redirects the flow of the program. An arithmetic unit produces both a data result and a fresh one-hot condition code for each executed instruction. Memory accesses go through a synchronous port with a read latency of one cycle. A sticky `halted` output ends execution.

Top module: `pred_cpu_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `halted` is 0 and the core fetches from address 0. Reset clears every register and the program counter, and sets the condition code to 4'b1111, so any instruction with a nonzero mask runs first.
- R2: An instruction whose mask ANDed with the condition code is zero writes no register, makes no data access and leaves the condition code unchanged. The next fetch is from the old PC + 1.
- R3: Instruction word fields are: bits [30:26] opcode, [25:22] mask, [21:18] destination, [17:14] source A, [13:10] source B, [9:0] offset in two's complement. The left operand is source A. The right operand is source B plus the sign-extended offset. Register 0 reads as zero and ignores writes.
- R4: Reading register 15 as a source gives the address of the current instruction. A write to register 15 overrides the increment, so the next fetch comes from the written value. A store whose data register is 15 stores the current address + 1.
- R5: The condition code is one-hot. It is 4'b1000 on overflow or divide by zero, and otherwise 4'b0001 for a zero result, 4'b0010 for a negative result and 4'b0100 for a positive result. It changes only when an instruction with a defined opcode executes.
- R6: LOAD (opcode 1) writes memory[left + right] to the destination register. STORE (opcode 2) writes the destination register to memory[left + right]. Both set the condition code from that sum.
- R7: HALT (opcode 0) raises `halted` from the next cycle on, and it stays high until reset. While it is high the core makes no memory access.
- R8: ADD (3), SUB (4), MUL (5) and DIV (6) write a wrapped 32-bit result. DIV rounds toward zero. Dividing by zero gives 0. The most negative value divided by -1 gives the most negative value. All of these overflow cases set 4'b1000.
- R9: Each instruction takes a fetch cycle (read enable, address = PC) and an execute cycle. LOAD adds one more cycle to return the data. Read and write enables are never high together.
- R10: An executed instruction with an undefined opcode (7 to 31) changes no register and no condition code. Only the program counter moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd_en | output | 1 | Read request; data returns on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | ADDR_W | Word address for the read or write |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, registered by the memory |
| halted | output | 1 | Sticky stop flag |

## Verification
Two things can land on the program counter in the same execute cycle: the automatic +1 step and a result whose destination is register 15. A load into register 15 creates a related case, where the step happens in the execute cycle and the loaded value replaces it one cycle later. The program provokes three kinds of jump: an add relative to the program counter, an absolute add guarded by the overflow condition, and a load into register 15. It also stores the program counter and reads it as a source. The bench judges the outcome by the address of the very next fetch and by the words stored to memory. A reference model of the instruction set predicts every memory access. Jumping over HALT words shows whether the step was wrongly allowed to win.

// File: rtl/pcore_pkg.sv
package pcore_pkg;

  localparam int OP_W    = 5;
  localparam int MASK_W  = 4;
  localparam int RIDX_W  = 4;
  localparam int OFF_W   = 10;
  localparam int FIELD_W = OP_W + MASK_W + 3 * RIDX_W + OFF_W;
  localparam int NUM_REGS = 1 << RIDX_W;
  localparam int PC_IDX   = NUM_REGS - 1;

  localparam logic [MASK_W-1:0] CC_ZERO = 4'b0001;
  localparam logic [MASK_W-1:0] CC_NEG  = 4'b0010;
  localparam logic [MASK_W-1:0] CC_POS  = 4'b0100;
  localparam logic [MASK_W-1:0] CC_OVF  = 4'b1000;
  localparam logic [MASK_W-1:0] CC_ALL  = 4'b1111;

  typedef enum logic [OP_W-1:0] {
    OPC_HALT  = 5'd0,
    OPC_LOAD  = 5'd1,
    OPC_STORE = 5'd2,
    OPC_ADD   = 5'd3,
    OPC_SUB   = 5'd4,
    OPC_MUL   = 5'd5,
    OPC_DIV   = 5'd6
  } opcode_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [MASK_W-1:0] mask;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [OFF_W-1:0]  off;
  } instr_t;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MEM   = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pcore_decode.sv
module pcore_decode
  import pcore_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [FIELD_W-1:0] word,
  input  logic [MASK_W-1:0]  cc,
  output logic [OP_W-1:0]    op,
  output logic [RIDX_W-1:0]  rt,
  output logic [RIDX_W-1:0]  rs1,
  output logic [RIDX_W-1:0]  rs2,
  output logic [DATA_W-1:0]  off_ext,
  output logic               pass,
  output logic               is_load,
  output logic               is_store,
  output logic               is_halt,
  output logic               is_arith
);

  localparam int EXT_W = DATA_W - OFF_W;

  instr_t fields;

  assign fields  = instr_t'(word);
  assign op      = fields.op;
  assign rt      = fields.rt;
  assign rs1     = fields.rs1;
  assign rs2     = fields.rs2;
  assign off_ext = {{EXT_W{fields.off[OFF_W-1]}}, fields.off};
  assign pass    = |(fields.mask & cc);

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_halt  = 1'b0;
    is_arith = 1'b0;
    case (fields.op)
      OPC_LOAD:  is_load  = 1'b1;
      OPC_STORE: is_store = 1'b1;
      OPC_HALT:  is_halt  = 1'b1;
      OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV: is_arith = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/pcore_alu.sv
module pcore_alu
  import pcore_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic [MASK_W-1:0] cc_out,
  output logic              known
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int HI_W   = DATA_W + 1;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] sum, diff, safe_div, quot;
  logic [PROD_W-1:0] prod;
  logic [HI_W-1:0]   prod_hi;
  logic              ovf_add, ovf_sub, ovf_mul, div_zero, div_wrap, ovf;

  assign sum     = a + b;
  assign diff    = a - b;
  assign ovf_add = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  assign ovf_sub = (a[DATA_W-1] != b[DATA_W-1]) && (diff[DATA_W-1] != a[DATA_W-1]);

  assign prod    = $signed({{DATA_W{a[DATA_W-1]}}, a}) * $signed({{DATA_W{b[DATA_W-1]}}, b});
  assign prod_hi = prod[PROD_W-1:DATA_W-1];
  assign ovf_mul = !((&prod_hi) || !(|prod_hi));

  assign div_zero = (b == '0);
  assign div_wrap = (a == MOST_NEG) && (b == ALL_ONES);
  assign safe_div = (div_zero || div_wrap) ? {{(DATA_W-1){1'b0}}, 1'b1} : b;
  assign quot     = $signed(a) / $signed(safe_div);

  always_comb begin
    res   = sum;
    ovf   = ovf_add;
    known = 1'b1;
    case (op)
      OPC_ADD, OPC_LOAD, OPC_STORE, OPC_HALT: begin
        res = sum;
        ovf = ovf_add;
      end
      OPC_SUB: begin
        res = diff;
        ovf = ovf_sub;
      end
      OPC_MUL: begin
        res = prod[DATA_W-1:0];
        ovf = ovf_mul;
      end
      OPC_DIV: begin
        if (div_zero) begin
          res = '0;
          ovf = 1'b1;
        end else if (div_wrap) begin
          res = MOST_NEG;
          ovf = 1'b1;
        end else begin
          res = quot;
          ovf = 1'b0;
        end
      end
      default: begin
        res   = '0;
        ovf   = 1'b0;
        known = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (ovf)                  cc_out = CC_OVF;
    else if (res == '0)       cc_out = CC_ZERO;
    else if (res[DATA_W-1])   cc_out = CC_NEG;
    else                      cc_out = CC_POS;
  end

endmodule

// File: rtl/pcore_regfile.sv
module pcore_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int PC_SLOT  = 15,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
  input  logic                           we,
  input  logic [IDX_W-1:0]               widx,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           pc_step,
  output logic [DATA_W-1:0]              pc
);

  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_SLOT);

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [DATA_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++) begin
        if (i != PC_SLOT && we && widx == IDX_W'(i)) bank[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          pc_q <= '0;
    else if (we && widx == PC_CODE)   pc_q <= wdata;
    else if (pc_step)                 pc_q <= pc_q + DATA_W'(1);
  end

  assign pc = pc_q;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)           rd_data[p] = '0;
      else if (rd_idx[p] == PC_CODE) rd_data[p] = pc_q;
      else                           rd_data[p] = bank[rd_idx[p]];
    end
  end

endmodule

// File: rtl/pred_cpu_core.sv
module pred_cpu_core
  import pcore_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

  seq_state_e        state_q, state_d;
  logic [MASK_W-1:0] cc_q, cc_d;
  logic              halted_q, halt_set;
  logic [RIDX_W-1:0] ld_rt_q;
  logic              ld_capture;

  logic [OP_W-1:0]   dec_op;
  logic [RIDX_W-1:0] dec_rt, dec_rs1, dec_rs2;
  logic [DATA_W-1:0] off_ext;
  logic              pred_pass, is_load, is_store, is_halt, is_arith;

  logic [2:0][RIDX_W-1:0] rd_idx;
  logic [2:0][DATA_W-1:0] rd_data;
  logic                   rf_we, pc_step;
  logic [RIDX_W-1:0]      rf_widx;
  logic [DATA_W-1:0]      rf_wdata, pc_val;

  logic [DATA_W-1:0] op_a, op_b, alu_res, store_data;
  logic [MASK_W-1:0] alu_cc;
  logic              alu_known;

  pcore_decode #(.DATA_W(DATA_W)) u_decode (
    .word     (mem_rdata[FIELD_W-1:0]),
    .cc       (cc_q),
    .op       (dec_op),
    .rt       (dec_rt),
    .rs1      (dec_rs1),
    .rs2      (dec_rs2),
    .off_ext  (off_ext),
    .pass     (pred_pass),
    .is_load  (is_load),
    .is_store (is_store),
    .is_halt  (is_halt),
    .is_arith (is_arith)
  );

  assign rd_idx = {dec_rt, dec_rs2, dec_rs1};

  pcore_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .PC_SLOT  (PC_IDX),
    .NUM_RD   (3)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .pc_step (pc_step),
    .pc      (pc_val)
  );

  assign op_a       = rd_data[0];
  assign op_b       = rd_data[1] + off_ext;
  assign store_data = (dec_rt == PC_CODE) ? pc_val + DATA_W'(1) : rd_data[2];

  pcore_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (dec_op),
    .a      (op_a),
    .b      (op_b),
    .res    (alu_res),
    .cc_out (alu_cc),
    .known  (alu_known)
  );

  always_comb begin
    state_d    = state_q;
    cc_d       = cc_q;
    mem_rd_en  = 1'b0;
    mem_wr_en  = 1'b0;
    mem_addr   = pc_val[ADDR_W-1:0];
    mem_wdata  = '0;
    rf_we      = 1'b0;
    rf_widx    = dec_rt;
    rf_wdata   = alu_res;
    pc_step    = 1'b0;
    halt_set   = 1'b0;
    ld_capture = 1'b0;
    case (state_q)
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        state_d   = ST_EXEC;
      end
      ST_EXEC: begin
        pc_step = 1'b1;
        state_d = ST_FETCH;
        if (pred_pass) begin
          if (alu_known) cc_d = alu_cc;
          if (is_load) begin
            mem_rd_en  = 1'b1;
            mem_addr   = alu_res[ADDR_W-1:0];
            ld_capture = 1'b1;
            state_d    = ST_MEM;
          end else if (is_store) begin
            mem_wr_en = 1'b1;
            mem_addr  = alu_res[ADDR_W-1:0];
            mem_wdata = store_data;
          end else if (is_halt) begin
            halt_set = 1'b1;
            state_d  = ST_HALT;
          end else if (is_arith) begin
            rf_we = 1'b1;
          end
        end
      end
      ST_MEM: begin
        rf_we    = 1'b1;
        rf_widx  = ld_rt_q;
        rf_wdata = mem_rdata;
        state_d  = ST_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      cc_q     <= CC_ALL;
      halted_q <= 1'b0;
      ld_rt_q  <= '0;
    end else begin
      state_q <= state_d;
      cc_q    <= cc_d;
      if (halt_set)   halted_q <= 1'b1;
      if (ld_capture) ld_rt_q  <= dec_rt;
    end
  end

  assign halted = halted_q;

endmodule

// File: rtl/pcore_checker.sv
module pcore_checker
  import pcore_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              halted,
  input logic [MASK_W-1:0] cc,
  input seq_state_e        state,
  input logic              pass,
  input logic [DATA_W-1:0] pc
);

  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  assert_fetch_to_exec_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_EXEC));

  assert_mem_to_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEM) |=> (state == ST_FETCH));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd_en && !mem_wr_en));

  assert_cc_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (cc != CC_ALL) |-> ($countones(cc) == 1));

  assert_skip_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !pass) |=> (pc == $past(pc) + DATA_W'(1)) && $stable(cc));

endmodule

bind pred_cpu_core pcore_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .halted    (halted),
  .cc        (cc_q),
  .state     (state_q),
  .pass      (pred_pass),
  .pc        (pc_val)
);

// File: tb/pred_cpu_core_bench.sv
module pred_cpu_core_bench;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MEMSZ = 1 << AW;
  localparam int OH = 0, OL = 1, OS = 2, OA = 3, OSB = 4, OM = 5, OD = 6;
  localparam int AL = 15, MZ = 1, MV = 8;

  typedef struct {
    bit          wr;
    int          addr;
    logic [31:0] data;
    string       tag;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_rd_en, mem_wr_en, halted;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [31:0] bmem [MEMSZ];
  logic [31:0] prog [MEMSZ];
  logic [31:0] mmem [MEMSZ];
  ev_t         ev_q[$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  pred_cpu_core #(.DATA_W(DW), .ADDR_W(AW)) u_pred_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  always #4ns clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    mem_rdata <= bmem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int op, int mask, int rt, int rs1, int rs2, int off);
    enc = {1'b0, 5'(op), 4'(mask), 4'(rt), 4'(rs1), 4'(rs2), 10'(off)};
  endfunction

  function automatic int cc_of(int r, bit ovf);
    if (ovf) return 8;
    if (r == 0) return 1;
    if (r < 0) return 2;
    return 4;
  endfunction

  task automatic ref_alu(input int op, input int a, input int b,
                         output int r, output int c, output bit known);
    longint w;
    bit ovf;
    known = 1'b1;
    ovf = 1'b0;
    r = 0;
    case (op)
      OH, OL, OS, OA: begin w = longint'(a) + longint'(b); r = int'(w); ovf = (w != longint'(r)); end
      OSB: begin w = longint'(a) - longint'(b); r = int'(w); ovf = (w != longint'(r)); end
      OM:  begin w = longint'(a) * longint'(b); r = int'(w); ovf = (w != longint'(r)); end
      OD: begin
        if (b == 0) begin r = 0; ovf = 1'b1; end
        else if (a == 32'h8000_0000 && b == -1) begin r = a; ovf = 1'b1; end
        else r = a / b;
      end
      default: known = 1'b0;
    endcase
    c = cc_of(r, ovf);
  endtask

  // Behavioural instruction-set model: lists every expected memory access
  task automatic run_model(output int total);
    int regs[16];
    int pc, pcn, cc, a, b, r, nc, op, mask, rt, rs1, rs2, off, steps;
    bit known, done;
    logic [31:0] w;
    string nt;
    for (int i = 0; i < 16; i++) regs[i] = 0;
    for (int i = 0; i < MEMSZ; i++) mmem[i] = prog[i];
    pc = 0; cc = 15; nt = "R1"; total = 0; done = 1'b0; steps = 0;
    ev_q.delete();
    while (!done && steps < 2000) begin
      steps++;
      ev_q.push_back('{1'b0, pc % MEMSZ, 32'h0, nt});
      total += 2;
      nt = "R9";
      w = mmem[pc % MEMSZ];
      op = int'(w[30:26]); mask = int'(w[25:22]); rt = int'(w[21:18]);
      rs1 = int'(w[17:14]); rs2 = int'(w[13:10]); off = int'($signed(w[9:0]));
      if ((mask & cc) == 0) begin
        pc = pc + 1;
        nt = "R2";
      end else begin
        a = (rs1 == 0) ? 0 : (rs1 == 15) ? pc : regs[rs1];
        b = ((rs2 == 0) ? 0 : (rs2 == 15) ? pc : regs[rs2]) + off;
        pcn = pc + 1;
        ref_alu(op, a, b, r, nc, known);
        case (op)
          OL: begin
            ev_q.push_back('{1'b0, r % MEMSZ, 32'h0, "R6"});
            total += 1;
            if (rt == 15) begin pcn = int'(mmem[r % MEMSZ]); nt = "R4"; end
            else if (rt != 0) regs[rt] = int'(mmem[r % MEMSZ]);
          end
          OS: begin
            w = (rt == 15) ? 32'(pc + 1) : (rt == 0) ? 32'h0 : 32'(regs[rt]);
            ev_q.push_back('{1'b1, r % MEMSZ, w, "R6"});
            mmem[r % MEMSZ] = w;
          end
          OH: done = 1'b1;
          OA, OSB, OM, OD: begin
            if (rt == 15) begin pcn = r; nt = "R4"; end
            else if (rt != 0) regs[rt] = r;
          end
          default: ;
        endcase
        if (known) cc = nc;
        pc = pcn;
      end
    end
  endtask

  task automatic build_prog();
    for (int i = 0; i < MEMSZ; i++) prog[i] = enc(OH, AL, 0, 0, 0, 0);
    prog[0]  = enc(OA, AL, 1, 0, 0, 5);
    prog[1]  = enc(OA, AL, 2, 0, 0, -3);
    prog[2]  = enc(OA, MZ, 3, 0, 0, 99);
    prog[3]  = enc(OSB, AL, 3, 1, 2, 0);
    prog[4]  = enc(OM, AL, 4, 3, 2, 0);
    prog[5]  = enc(OD, AL, 5, 4, 1, 0);
    prog[6]  = enc(OD, AL, 6, 1, 0, 0);
    prog[7]  = enc(OA, MV, 7, 0, 0, 1);
    prog[8]  = enc(OA, AL, 0, 1, 1, 0);
    prog[9]  = enc(OA, AL, 8, 0, 0, 0);
    prog[10] = enc(OS, AL, 1, 0, 0, 200);
    prog[11] = enc(OL, AL, 9, 0, 0, 200);
    prog[12] = enc(OS, AL, 15, 0, 0, 201);
    prog[13] = enc(OA, AL, 10, 15, 0, 0);
    prog[14] = enc(OA, AL, 15, 15, 0, 3);
    prog[17] = enc(OL, AL, 12, 0, 0, 210);
    prog[18] = enc(OA, AL, 13, 12, 0, 1);
    prog[19] = enc(OM, AL, 14, 12, 12, 0);
    prog[20] = enc(31, AL, 1, 0, 0, 7);
    prog[21] = enc(OA, MV, 15, 0, 0, 24);
    prog[24] = enc(OL, AL, 15, 0, 0, 211);
    prog[26] = enc(OD, AL, 14, 13, 0, -1);
    prog[27] = enc(OH, 0, 0, 0, 0, 0);
    prog[28] = enc(OS, AL, 14, 0, 0, 202);
    prog[29] = enc(OS, AL, 10, 0, 0, 203);
    prog[30] = enc(OS, AL, 5, 0, 0, 204);
    prog[31] = enc(OS, AL, 6, 0, 0, 205);
    prog[32] = enc(OS, AL, 8, 0, 0, 206);
    prog[33] = enc(OS, AL, 9, 0, 0, 207);
    prog[34] = enc(OS, AL, 7, 0, 0, 208);
    prog[35] = enc(OS, AL, 3, 0, 0, 209);
    prog[36] = enc(OS, AL, 1, 0, 0, 212);
    prog[37] = enc(OH, AL, 0, 0, 0, 0);
    prog[210] = 32'h7FFF_FFFF;
    prog[211] = 32'd26;
  endtask

  task automatic run_once();
    int total, exp_halt, cyc;
    ev_t e;
    for (int i = 0; i < MEMSZ; i++) bmem[i] = prog[i];
    run_model(total);
    exp_halt = total + 1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(halted == 1'b0, "R1", "halted during reset", 32'(halted), 32'h0);
    rst = 1'b0;
    chk(mem_rd_en && mem_addr == '0, "R1", "first fetch address", 32'(mem_addr), 32'h0);
    cyc = 0;
    while (cyc < exp_halt + 5) begin
      cyc++;
      chk(!(mem_rd_en && mem_wr_en), "R9", "read and write together",
          {mem_rd_en, mem_wr_en}, 32'h0);
      chk(halted == (cyc >= exp_halt), "R7", "halted flag",
          32'(halted), 32'(cyc >= exp_halt));
      if (mem_rd_en || mem_wr_en) begin
        if (ev_q.size() == 0) begin
          chk(1'b0, "R7", "access after halt", 32'(mem_addr), 32'h0);
        end else begin
          e = ev_q.pop_front();
          chk(mem_wr_en == e.wr && mem_addr == AW'(e.addr), e.tag, "access kind/address",
              {mem_wr_en, 21'h0, mem_addr}, {e.wr, 21'h0, AW'(e.addr)});
          if (e.wr)
            chk(mem_wdata == e.data, e.tag, "store data", mem_wdata, e.data);
        end
      end
      @(negedge clk);
    end
    chk(ev_q.size() == 0, "R9", "accesses left unperformed", 32'(ev_q.size()), 32'h0);
    for (int i = 200; i < 214; i++)
      chk(bmem[i] == mmem[i], "R6", "memory image", bmem[i], mmem[i]);
    chk(bmem[200] == 32'd5, "R6", "store of r1", bmem[200], 32'd5);
    chk(bmem[201] == 32'd13, "R4", "store of PC gives next address", bmem[201], 32'd13);
    chk(bmem[202] == 32'h8000_0000, "R8", "most negative / -1", bmem[202], 32'h8000_0000);
    chk(bmem[203] == 32'd13, "R4", "PC read as source", bmem[203], 32'd13);
    chk(bmem[204] == 32'hFFFF_FFFC, "R8", "divide rounds toward zero", bmem[204], 32'hFFFF_FFFC);
    chk(bmem[205] == 32'd0, "R8", "divide by zero result", bmem[205], 32'd0);
    chk(bmem[206] == 32'd0, "R3", "register 0 ignores writes", bmem[206], 32'd0);
    chk(bmem[207] == 32'd5, "R6", "load result", bmem[207], 32'd5);
    chk(bmem[208] == 32'd1, "R5", "overflow code enables mask 1000", bmem[208], 32'd1);
    chk(bmem[209] == 32'd8, "R2", "skipped write absent", bmem[209], 32'd8);
    chk(bmem[212] == 32'd5, "R10", "undefined opcode left r1", bmem[212], 32'd5);
  endtask

  initial begin
    build_prog();
    run_once();
    run_once();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule